// File: doc/BRIEF.md
# Segment lookaside buffer

A small, fully associative table that translates the segment part of a 64-bit effective address into a segment descriptor. Every slot holds two 64-bit words: a tag word, carrying the segment number and a valid flag, and a descriptor word, whose two top bits give the slot's segment size. A slot covers either a 256 MB segment or a 1 TB segment. The address is compared under the mask that the slot's own size field selects, so both sizes can share the table.

A dedicated lookup port returns the hit flag, the winning slot and its descriptor one cycle after a request. A command port carries seven operations:

- a checked indexed write;
- indexed reads of either word;
- an associative search that returns the descriptor;
- a single-entry invalidate;
- a bulk invalidate.

The two invalidates raise translation-cache flush requests. The bulk invalidate never touches slot 0, so a boot or kernel segment placed there survives it.

Datapath layout: the tag word has the segment number in bits [63:28], the valid flag in bit 27, and bits [26:0] zero. The descriptor size field is bits [63:62], with 00 = 256 MB and 01 = 1 TB. Commands are single-cycle operations, decoded by an enumerated opcode: `OP_NOP`, `OP_WRITE`, `OP_RD_TAG`, `OP_RD_DESC`, `OP_FIND`, `OP_INV_ONE` and `OP_INV_ALL`. There is no multi-cycle state; the only state is the table. Its one transition happens at each clock edge, from the current table to the next table that the decoded command selects.

Top module: `seg_lookaside`

## Requirements
- R1: After reset every slot's tag and descriptor words read as zero, all outputs are zero and every lookup misses.
- R2: `OP_WRITE` (code 1) takes the slot from operand bits [11:0] and stores the operand, with bits [11:0] cleared, as the tag word. It stores `cmd_data` as the descriptor. A slot written with tag bit 27 clear never hits.
- R3: A write whose slot field (operand bits [11:0]) is not below NUM_SLOTS is rejected: `rsp_err` is set and the table is unchanged.
- R4: A write with any of operand bits [26:12] set is rejected with `rsp_err` and leaves the table unchanged.
- R5: A write whose descriptor bits [63:62] are 10 or 11 is rejected. So is a write of a 1 TB descriptor (01) while `en_1t` is low. A rejected write leaves the table unchanged.
- R6: A slot of size 00 hits when its tag equals {address[63:28], 1, 27 zeros}.
- R7: A slot of size 01 hits when its tag equals {address[63:40], 12 zeros, 1, 27 zeros}. Address bits [39:28] are ignored for such a slot.
- R8: Lookup results appear on the cycle after `lk_valid`, with `lk_done` set. When several slots hit, the lowest-numbered one is reported. A miss gives hit, slot and descriptor all zero.
- R9: `OP_RD_TAG` (2) and `OP_RD_DESC` (3) return the word of the slot in operand bits [11:0]. A slot number not below NUM_SLOTS gives `rsp_err` and data zero.
- R10: `OP_FIND` (4) searches with operand bits [63:28]. It returns the winning descriptor on a hit and all ones on a miss. With `mode64` low it returns `rsp_err` and data zero.
- R11: `OP_INV_ONE` (5) clears bit 27 of the lowest matching slot. On a hit it pulses `flush_global` when `cmd_global` is set and `flush_local` otherwise. On a miss it raises no flush.
- R12: `OP_INV_ALL` (6) clears bit 27 in slots 1 to NUM_SLOTS-1, leaves slot 0 intact, and pulses `flush_local` only if some slot was valid before.
- R13: `rsp_valid` pulses on the cycle after each non-NOP command. The flush outputs are one-cycle pulses and are never raised together with `rsp_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en_1t | input | 1 | Allows 1 TB segments to be written |
| mode64 | input | 1 | Processor in 64-bit mode (gates OP_FIND) |
| lk_valid | input | 1 | Lookup request |
| lk_seg | input | 36 | Effective address bits [63:28] to look up |
| lk_done | output | 1 | Lookup result valid |
| lk_hit | output | 1 | Lookup hit |
| lk_slot | output | 3 | Winning slot |
| lk_desc | output | 64 | Descriptor word of winning slot |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command opcode |
| cmd_opnd | input | 64 | Tag/slot operand or search address |
| cmd_data | input | 64 | Descriptor word for writes |
| cmd_global | input | 1 | Single invalidate requests global flush |
| rsp_valid | output | 1 | Command completed |
| rsp_err | output | 1 | Command rejected |
| rsp_data | output | 64 | Read or search result |
| flush_local | output | 1 | Local translation-cache flush request |
| flush_global | output | 1 | Global translation-cache flush request |

## Verification
The bench builds the block with its default of eight slots. This allows a full sweep of every illegal slot field from 8 to 4095, of every reserved tag bit and of all four size codes. With both segment sizes mixed in one small table, every slot can be read back and looked up after each step. Overlapping 256 MB and 1 TB entries can be placed at chosen slots, which shows the lowest-slot priority and the slot-0 exemption of the bulk invalidate. The expected results come from a per-slot reference table in the bench.

// File: rtl/slb_pkg.sv
package slb_pkg;
    localparam int EA_W          = 64;
    localparam int VALID_BIT     = 27;
    localparam int SEG_SMALL_LSB = 28;
    localparam int SEG_LARGE_LSB = 40;
    localparam int SEG_W         = EA_W - SEG_SMALL_LSB;
    localparam int SLOT_FIELD_W  = 12;
    localparam int SIZE_LSB      = EA_W - 2;

    localparam logic [1:0] SZ_SMALL = 2'b00;
    localparam logic [1:0] SZ_LARGE = 2'b01;

    typedef enum logic [2:0] {
        OP_NOP     = 3'd0,
        OP_WRITE   = 3'd1,
        OP_RD_TAG  = 3'd2,
        OP_RD_DESC = 3'd3,
        OP_FIND    = 3'd4,
        OP_INV_ONE = 3'd5,
        OP_INV_ALL = 3'd6
    } slb_op_e;

    typedef struct packed {
        logic [EA_W-1:0] tag;
        logic [EA_W-1:0] desc;
    } slb_entry_t;
endpackage

// File: rtl/slb_match.sv
module slb_match
    import slb_pkg::*;
#(
    parameter int NUM_SLOTS = 8
) (
    input  logic [SEG_W-1:0]                 seg,
    input  logic [NUM_SLOTS-1:0][EA_W-1:0]   tags,
    input  logic [NUM_SLOTS-1:0][1:0]        sizes,
    output logic [NUM_SLOTS-1:0]             hit_vec
);
    logic [EA_W-1:0] key_small;
    logic [EA_W-1:0] key_large;

    always_comb begin
        key_small = '0;
        key_small[EA_W-1:SEG_SMALL_LSB] = seg;
        key_small[VALID_BIT] = 1'b1;
        key_large = '0;
        key_large[EA_W-1:SEG_LARGE_LSB] = seg[SEG_W-1:SEG_LARGE_LSB-SEG_SMALL_LSB];
        key_large[VALID_BIT] = 1'b1;
    end

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_cmp
        assign hit_vec[g] = ((sizes[g] == SZ_SMALL) && (tags[g] == key_small))
                         || ((sizes[g] == SZ_LARGE) && (tags[g] == key_large));
    end
endmodule

// File: rtl/slb_prio.sv
module slb_prio #(
    parameter int NUM_SLOTS = 8,
    localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
    input  logic [NUM_SLOTS-1:0] hit_vec,
    output logic                 any,
    output logic [SLOT_W-1:0]    idx
);
    always_comb begin
        any = |hit_vec;
        idx = '0;
        for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
            if (hit_vec[i]) idx = i[SLOT_W-1:0];
        end
    end
endmodule

// File: rtl/slb_wcheck.sv
module slb_wcheck
    import slb_pkg::*;
#(
    parameter int NUM_SLOTS = 8
) (
    input  logic [SLOT_FIELD_W-1:0]           slot_field,
    input  logic [VALID_BIT-1:SLOT_FIELD_W]   resv_field,
    input  logic [1:0]                        size_field,
    input  logic                              en_1t,
    output logic                              bad_slot,
    output logic                              wr_err
);
    logic bad_size;
    logic no_large;

    always_comb begin
        bad_slot = int'(slot_field) >= NUM_SLOTS;
        bad_size = (size_field != SZ_SMALL) && (size_field != SZ_LARGE);
        no_large = (size_field == SZ_LARGE) && !en_1t;
        wr_err   = bad_slot || (|resv_field) || bad_size || no_large;
    end
endmodule

// File: rtl/seg_lookaside.sv
module seg_lookaside
    import slb_pkg::*;
#(
    parameter int NUM_SLOTS = 8,
    localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en_1t,
    input  logic                mode64,
    input  logic                lk_valid,
    input  logic [SEG_W-1:0]    lk_seg,
    output logic                lk_done,
    output logic                lk_hit,
    output logic [SLOT_W-1:0]   lk_slot,
    output logic [EA_W-1:0]     lk_desc,
    input  logic                cmd_valid,
    input  logic [2:0]          cmd_op,
    input  logic [EA_W-1:0]     cmd_opnd,
    input  logic [EA_W-1:0]     cmd_data,
    input  logic                cmd_global,
    output logic                rsp_valid,
    output logic                rsp_err,
    output logic [EA_W-1:0]     rsp_data,
    output logic                flush_local,
    output logic                flush_global
);
    slb_entry_t [NUM_SLOTS-1:0]      tbl;
    slb_entry_t [NUM_SLOTS-1:0]      tbl_nxt;
    logic [NUM_SLOTS-1:0][EA_W-1:0]  tags;
    logic [NUM_SLOTS-1:0][1:0]       sizes;
    logic [NUM_SLOTS-1:0]            l_hits, c_hits;
    logic                            l_any, c_any;
    logic [SLOT_W-1:0]               l_idx, c_idx;
    logic                            bad_slot, wr_err;
    logic [SLOT_W-1:0]               sidx;
    slb_op_e                         op;
    logic                            n_err, n_floc, n_fglb;
    logic [EA_W-1:0]                 n_data;

    assign op   = slb_op_e'(cmd_op);
    assign sidx = cmd_opnd[SLOT_W-1:0];

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_view
        assign tags[g]  = tbl[g].tag;
        assign sizes[g] = tbl[g].desc[EA_W-1:SIZE_LSB];
    end

    slb_match #(.NUM_SLOTS(NUM_SLOTS)) i_lk_match (
        .seg(lk_seg), .tags(tags), .sizes(sizes), .hit_vec(l_hits));
    slb_prio #(.NUM_SLOTS(NUM_SLOTS)) i_lk_prio (
        .hit_vec(l_hits), .any(l_any), .idx(l_idx));
    slb_match #(.NUM_SLOTS(NUM_SLOTS)) i_cmd_match (
        .seg(cmd_opnd[EA_W-1:SEG_SMALL_LSB]), .tags(tags), .sizes(sizes), .hit_vec(c_hits));
    slb_prio #(.NUM_SLOTS(NUM_SLOTS)) i_cmd_prio (
        .hit_vec(c_hits), .any(c_any), .idx(c_idx));
    slb_wcheck #(.NUM_SLOTS(NUM_SLOTS)) i_wcheck (
        .slot_field(cmd_opnd[SLOT_FIELD_W-1:0]),
        .resv_field(cmd_opnd[VALID_BIT-1:SLOT_FIELD_W]),
        .size_field(cmd_data[EA_W-1:SIZE_LSB]),
        .en_1t(en_1t), .bad_slot(bad_slot), .wr_err(wr_err));

    // next-table and response decode
    always_comb begin
        tbl_nxt = tbl;
        n_err   = 1'b0;
        n_data  = '0;
        n_floc  = 1'b0;
        n_fglb  = 1'b0;
        if (cmd_valid) begin
            unique case (op)
                OP_WRITE: begin
                    if (wr_err) n_err = 1'b1;
                    else begin
                        tbl_nxt[sidx].tag  = {cmd_opnd[EA_W-1:SLOT_FIELD_W], {SLOT_FIELD_W{1'b0}}};
                        tbl_nxt[sidx].desc = cmd_data;
                    end
                end
                OP_RD_TAG: begin
                    if (bad_slot) n_err = 1'b1;
                    else n_data = tbl[sidx].tag;
                end
                OP_RD_DESC: begin
                    if (bad_slot) n_err = 1'b1;
                    else n_data = tbl[sidx].desc;
                end
                OP_FIND: begin
                    if (!mode64) n_err = 1'b1;
                    else if (c_any) n_data = tbl[c_idx].desc;
                    else n_data = '1;
                end
                OP_INV_ONE: begin
                    if (c_any) begin
                        tbl_nxt[c_idx].tag[VALID_BIT] = 1'b0;
                        if (cmd_global) n_fglb = 1'b1;
                        else n_floc = 1'b1;
                    end
                end
                OP_INV_ALL: begin
                    for (int i = 1; i < NUM_SLOTS; i++) begin
                        if (tbl[i].tag[VALID_BIT]) begin
                            tbl_nxt[i].tag[VALID_BIT] = 1'b0;
                            n_floc = 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // table state register
    always_ff @(posedge clk) begin
        if (!rst_n) tbl <= '0;
        else        tbl <= tbl_nxt;
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lk_done      <= 1'b0;
            lk_hit       <= 1'b0;
            lk_slot      <= '0;
            lk_desc      <= '0;
            rsp_valid    <= 1'b0;
            rsp_err      <= 1'b0;
            rsp_data     <= '0;
            flush_local  <= 1'b0;
            flush_global <= 1'b0;
        end else begin
            lk_done      <= lk_valid;
            lk_hit       <= lk_valid && l_any;
            lk_slot      <= (lk_valid && l_any) ? l_idx : '0;
            lk_desc      <= (lk_valid && l_any) ? tbl[l_idx].desc : '0;
            rsp_valid    <= cmd_valid && (op != OP_NOP);
            rsp_err      <= n_err;
            rsp_data     <= n_data;
            flush_local  <= n_floc;
            flush_global <= n_fglb;
        end
    end
endmodule

// File: rtl/slb_checker.sv
module slb_checker
    import slb_pkg::*;
#(
    parameter int NUM_SLOTS = 8
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     mode64,
    input logic                     lk_valid,
    input logic                     lk_done,
    input logic                     lk_hit,
    input logic                     cmd_valid,
    input logic [2:0]               cmd_op,
    input logic                     rsp_valid,
    input logic                     rsp_err,
    input logic                     flush_local,
    input logic                     flush_global,
    input logic [NUM_SLOTS*128-1:0] tbl_flat,
    input logic [EA_W-1:0]          tag0
);
    a_r13_rsp_after_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op != 3'd0) |=> rsp_valid);
    a_r13_no_rsp_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> !rsp_valid);
    a_r13_err_no_flush: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (!flush_local && !flush_global));
    a_r11_flush_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(flush_local && flush_global));
    a_r12_bulk_local_only: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 3'd6) |=> !flush_global);
    a_r12_slot0_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 3'd6) |=> $stable(tag0));
    a_r10_find_needs_mode64: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 3'd4 && !mode64) |=> rsp_err);
    a_r5_err_keeps_table: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> $stable(tbl_flat));
    a_r8_lookup_done: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> lk_done);
    a_r8_no_hit_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> (!lk_hit && !lk_done));
endmodule

bind seg_lookaside slb_checker #(.NUM_SLOTS(NUM_SLOTS)) i_slb_checker (
    .clk(clk), .rst_n(rst_n), .mode64(mode64), .lk_valid(lk_valid),
    .lk_done(lk_done), .lk_hit(lk_hit), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .flush_local(flush_local),
    .flush_global(flush_global), .tbl_flat(tbl), .tag0(tbl[0].tag));

// File: tb/test_seg_lookaside.sv
module test_seg_lookaside;
    localparam int N = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en_1t = 1'b1, mode64 = 1'b1;
    logic        lk_valid = 1'b0;
    logic [35:0] lk_seg = '0;
    logic        lk_done, lk_hit;
    logic [2:0]  lk_slot;
    logic [63:0] lk_desc;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = '0;
    logic [63:0] cmd_opnd = '0, cmd_data = '0;
    logic        cmd_global = 1'b0;
    logic        rsp_valid, rsp_err, flush_local, flush_global;
    logic [63:0] rsp_data;

    int n_chk = 0, n_fail = 0;
    logic [63:0] m_tag [N];
    logic [63:0] m_desc [N];

    always #5 clk = ~clk;

    seg_lookaside #(.NUM_SLOTS(N)) i_seg_lookaside (.*);

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cmd(logic [2:0] op, logic [63:0] opnd, logic [63:0] data, logic glb);
        cmd_valid = 1'b1; cmd_op = op; cmd_opnd = opnd; cmd_data = data; cmd_global = glb;
        @(posedge clk); @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 3'd0;
    endtask

    task automatic lookup(logic [35:0] seg);
        lk_valid = 1'b1; lk_seg = seg;
        @(posedge clk); @(negedge clk);
        lk_valid = 1'b0;
    endtask

    function automatic int ref_find(logic [35:0] seg);
        for (int i = 0; i < N; i++) begin
            if (m_tag[i][27] && m_desc[i][63:62] == 2'b00 && m_tag[i] == {seg, 1'b1, 27'b0}) return i;
            if (m_tag[i][27] && m_desc[i][63:62] == 2'b01 && m_tag[i] == {seg[35:12], 12'b0, 1'b1, 27'b0}) return i;
        end
        return -1;
    endfunction

    task automatic chk_lookup(string tag, logic [35:0] seg);
        int e;
        e = ref_find(seg);
        lookup(seg);
        check({tag, " done"}, 64'(lk_done), 64'(1));
        check({tag, " hit"}, 64'(lk_hit), 64'(e >= 0));
        check({tag, " slot"}, 64'(lk_slot), (e >= 0) ? 64'(e) : 64'(0));
        check({tag, " desc"}, lk_desc, (e >= 0) ? m_desc[e] : 64'(0));
    endtask

    task automatic good_write(int s, logic [35:0] seg, logic v, logic [63:0] desc);
        logic [63:0] w;
        w = {seg, v, 15'b0, 12'(s)};
        cmd(3'd1, w, desc, 1'b0);
        check("R2 write accepted", 64'(rsp_err), 64'(0));
        check("R13 rsp_valid after write", 64'(rsp_valid), 64'(1));
        m_tag[s] = {w[63:12], 12'b0};
        m_desc[s] = desc;
    endtask

    task automatic bad_write(string tag, logic [63:0] opnd, logic [63:0] desc);
        cmd(3'd1, opnd, desc, 1'b0);
        check(tag, 64'(rsp_err), 64'(1));
    endtask

    task automatic read_all(string tag);
        for (int s = 0; s < N; s++) begin
            cmd(3'd2, 64'(s), 64'(0), 1'b0);
            check({tag, " tag word"}, rsp_data, m_tag[s]);
            cmd(3'd3, 64'(s), 64'(0), 1'b0);
            check({tag, " desc word"}, rsp_data, m_desc[s]);
        end
    endtask

    task automatic find_chk(string tag, logic [35:0] seg);
        int e;
        e = ref_find(seg);
        cmd(3'd4, {seg, 28'b0}, 64'(0), 1'b0);
        check({tag, " err"}, 64'(rsp_err), 64'(0));
        check({tag, " data"}, rsp_data, (e >= 0) ? m_desc[e] : '1);
    endtask

    function automatic logic [35:0] small_seg(int s);
        return {24'(100 + s), 12'(s + 7)};
    endfunction
    function automatic logic [35:0] large_seg(int s);
        return {24'(200 + s), 12'h0};
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        for (int s = 0; s < N; s++) begin m_tag[s] = '0; m_desc[s] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 rsp_valid reset", 64'(rsp_valid), 64'(0));
        check("R1 lk_done reset", 64'(lk_done), 64'(0));
        check("R1 flush reset", 64'({flush_local, flush_global}), 64'(0));
        read_all("R1");
        chk_lookup("R1 lookup zero", 36'h0);

        // R2 fill: even slots 256 MB, odd slots 1 TB
        for (int s = 0; s < N; s++) begin
            if (s % 2 == 0) good_write(s, small_seg(s), 1'b1, {2'b00, 62'(64'hA000 + s)});
            else            good_write(s, large_seg(s), 1'b1, {2'b01, 62'(64'hB000 + s)});
        end
        read_all("R2 R9");

        // R6 R7 lookups
        for (int s = 0; s < N; s++) begin
            if (s % 2 == 0) begin
                chk_lookup("R6 small hit", small_seg(s));
                chk_lookup("R6 small neighbour miss", small_seg(s) + 36'd1);
            end else begin
                for (int k = 0; k < 4096; k += 273)
                    chk_lookup("R7 large hit any low bits", large_seg(s) | 36'(k));
                chk_lookup("R7 large neighbour miss", large_seg(s) + 36'h1000);
            end
        end

        // R2 entry written invalid never hits
        good_write(6, small_seg(40), 1'b0, 64'h0000_0000_0000_0666);
        chk_lookup("R2 invalid entry misses", small_seg(40));

        // R3 slot sweep
        for (int f = N; f < 4096; f++)
            bad_write("R3 slot out of range", {small_seg(50), 1'b1, 15'b0, 12'(f)}, 64'h1);
        // R4 reserved bits
        for (int b = 12; b < 27; b++)
            bad_write("R4 reserved bit", {small_seg(51), 1'b1, 27'b0} | (64'd1 << b) | 64'd2, 64'h2);
        // R5 size codes
        bad_write("R5 size code 10", {small_seg(52), 1'b1, 27'd3}, {2'b10, 62'h3});
        bad_write("R5 size code 11", {small_seg(52), 1'b1, 27'd3}, {2'b11, 62'h3});
        en_1t = 1'b0;
        bad_write("R5 1TB disabled", {large_seg(53), 1'b1, 27'd3}, {2'b01, 62'h3});
        en_1t = 1'b1;
        read_all("R5 table unchanged");

        // R9 indexed read of bad slots
        for (int f = N; f < N + 8; f++) begin
            cmd(3'd2, 64'(f), 64'(0), 1'b0);
            check("R9 bad tag read err", 64'(rsp_err), 64'(1));
            check("R9 bad tag read data", rsp_data, 64'(0));
            cmd(3'd3, 64'(f), 64'(0), 1'b0);
            check("R9 bad desc read err", 64'(rsp_err), 64'(1));
        end

        // R8 priority: same 256 MB segment in slots 2 and 5
        good_write(5, small_seg(2), 1'b1, {2'b00, 62'h5555});
        chk_lookup("R8 lowest slot wins", small_seg(2));
        // 256 MB entry at slot 4 and 1 TB entry at slot 3 covering it
        good_write(4, {24'(203), 12'h00A}, 1'b1, {2'b00, 62'h4444});
        chk_lookup("R8 large slot 3 over small slot 4", {24'(203), 12'h00A});
        chk_lookup("R8 miss", 36'hF_FFFF_FFFF);

        // R10 find
        find_chk("R10 find hit", small_seg(0));
        find_chk("R10 find large hit", large_seg(7) | 36'h123);
        find_chk("R10 find miss", 36'h0_0000_0001);
        mode64 = 1'b0;
        cmd(3'd4, {small_seg(0), 28'b0}, 64'(0), 1'b0);
        check("R10 find 32-bit err", 64'(rsp_err), 64'(1));
        check("R10 find 32-bit data", rsp_data, 64'(0));
        mode64 = 1'b1;

        // R11 single invalidate
        cmd(3'd5, {small_seg(2), 28'b0}, 64'(0), 1'b0);
        m_tag[2][27] = 1'b0;
        check("R11 local flush", 64'({flush_local, flush_global}), 64'b10);
        @(negedge clk);
        check("R13 flush one cycle", 64'({flush_local, flush_global}), 64'b00);
        chk_lookup("R11 next match slot 5", small_seg(2));
        cmd(3'd5, {large_seg(1), 28'b0}, 64'(0), 1'b1);
        m_tag[1][27] = 1'b0;
        check("R11 global flush", 64'({flush_local, flush_global}), 64'b01);
        cmd(3'd5, {36'h0_0000_0001, 28'b0}, 64'(0), 1'b1);
        check("R11 miss no flush", 64'({flush_local, flush_global}), 64'b00);
        read_all("R11 state");

        // R12 bulk invalidate
        cmd(3'd6, 64'(0), 64'(0), 1'b0);
        for (int s = 1; s < N; s++) m_tag[s][27] = 1'b0;
        check("R12 bulk flush", 64'({flush_local, flush_global}), 64'b10);
        read_all("R12 state");
        chk_lookup("R12 slot 0 kept", small_seg(0));
        chk_lookup("R12 slot 7 gone", large_seg(7));
        cmd(3'd6, 64'(0), 64'(0), 1'b0);
        check("R12 nothing cleared no flush", 64'({flush_local, flush_global}), 64'b00);
        check("R13 bulk rsp_valid", 64'(rsp_valid), 64'(1));

        // R13 NOP gives no response
        cmd(3'd0, 64'(0), 64'(0), 1'b0);
        check("R13 nop no response", 64'(rsp_valid), 64'(0));

        // R1 reset again clears everything
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int s = 0; s < N; s++) begin m_tag[s] = '0; m_desc[s] = '0; end
        read_all("R1 after reset");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule